// File: doc/BRIEF.md
# Segmented DAC Switch-Matrix Decoder

This block is the digital front end of an 8-bit current-steering converter whose output cells are split into two groups. The five upper code bits choose how many of 31 identical large cells are switched on. The three lower code bits drive three small binary-weighted cells. A code is captured on each rising clock edge. It is then decoded, and the decoded enables are registered a second time. Registering after the decoder means every switch changes on the same edge, with no decoder skew between cells.

Each switch has a pair of legs. The A leg steers its cell's current to the true output and the B leg steers it to the complementary output. The currents on the two outputs therefore always add up to the same total. An active-high sleep input turns every leg off and freezes both register stages. A synchronous active-low reset sets the pipeline to code zero.

Top module: `segdac_switch_front`

## Requirements
- R1: A code applied at `code_i` is sampled on a rising edge of `clk`. The switch outputs reflect it after the second rising edge following that sample point, so the latency is two edges.
- R2: `seg_a_o[k]` is high exactly when the value of `code_i[7:3]` is greater than k, for k from 0 to 30. The 31 segment enables therefore always form a thermometer code that fills from bit 0 upward. Each segment weighs 8 LSB.
- R3: `bin_a_o[i]` equals code bit i for i from 0 to 2. These bits carry weights of 1, 2 and 4 LSB.
- R4: Outside sleep, every B leg is the inverse of its A leg: `seg_b_o == ~seg_a_o` and `bin_b_o == ~bin_a_o`.
- R5: Outside sleep, the A-side weighted sum (8 per segment plus the binary weights) equals the code value. The A and B sums together always total 255.
- R6: When the code steps from a value whose low three bits are 111 to the next code, all three binary enables go low and exactly one more segment enable goes high.
- R7: While `sleep_i` is high, every A and B output is low.
- R8: While `sleep_i` is high, both register stages hold their contents, and codes applied during sleep never enter the pipeline. When sleep falls, the held stage-two code appears at once. Fresh codes follow after two edges.
- R9: With `rst_n` low at a rising edge, both stages clear to code 0x00. The outputs then show every A leg low and every B leg high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_i | input | 1 | Power-down request, active high |
| code_i | input | 8 | Input code, bit 7 most significant |
| seg_a_o | output | 31 | Segment legs steering to output A |
| seg_b_o | output | 31 | Segment legs steering to output B |
| bin_a_o | output | 3 | Binary-cell legs steering to output A |
| bin_b_o | output | 3 | Binary-cell legs steering to output B |

## Verification
A full ramp through all 256 codes exercises every carry out of the low three bits. A decoder with an off-by-one comparison would light a segment one code early or late at these carries, and a wrong carry would turn on two segments or leave a binary cell on. The extreme codes 0x00, 0x7F, 0x80 and 0xFF check the end points of the thermometer and the midscale balance, where a swapped leg would break the sum of 255. A sleep window that changes the input code shows whether a register was wrongly left enabled, because the pre-sleep code would then be lost when sleep falls. A reset applied in mid-stream shows whether a stage fails to clear, because a B leg would then stay low.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
   // default geometry of the converter front end
   localparam int unsigned CODE_W_DEF = 8;
   localparam int unsigned BIN_W_DEF  = 3;

   // number of equal cells driven by a thermometer of the given width
   function automatic int unsigned therm_cells(input int unsigned hi_w);
      return (1 << hi_w) - 1;
   endfunction

   // weight of one equal cell, in LSB units
   function automatic int unsigned cell_weight(input int unsigned lo_w);
      return 1 << lo_w;
   endfunction
endpackage

// File: rtl/segdac_code_reg.sv
module segdac_code_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_w
      $error("segdac_code_reg: width must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (!hold) q <= d;
   end

   // a held stage must not move while sleep keeps it frozen
   AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hold) && $past(rst_n)) |-> $stable(q)); // R8
endmodule

// File: rtl/segdac_decoder.sv
module segdac_decoder
   import segdac_pkg::*;
#(
   parameter int unsigned CODE_W = CODE_W_DEF,
   parameter int unsigned BIN_W  = BIN_W_DEF,
   localparam int unsigned HI_W  = CODE_W - BIN_W,
   localparam int unsigned SEG_N = therm_cells(HI_W)
) (
   input  logic [CODE_W-1:0] code,
   output logic [SEG_N-1:0]  therm,
   output logic [BIN_W-1:0]  bin
);
   if (BIN_W < 1 || BIN_W >= CODE_W) begin : g_bad_split
      $error("segdac_decoder: binary part must be 1..CODE_W-1 bits");
   end
   if (HI_W > 8) begin : g_bad_hi
      $error("segdac_decoder: thermometer part too wide");
   end

   logic [HI_W-1:0] hi_val;
   assign hi_val = code[CODE_W-1:BIN_W];
   assign bin    = code[BIN_W-1:0];

   // one comparator per equal cell; cell k conducts when the upper value exceeds k
   for (genvar k = 0; k < SEG_N; k++) begin : g_cell
      assign therm[k] = ({1'b0, hi_val} > (HI_W + 1)'(k));
   end

   // a thermometer has no hole: adding one clears every set bit
   always_comb begin
      if (!$isunknown(code)) begin
         AST_THERM_SHAPE: assert ((therm & (therm + 1'b1)) == '0); // R2
      end
   end
endmodule

// File: rtl/segdac_switch_reg.sv
module segdac_switch_reg #(
   parameter int unsigned N = 34
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (N < 2) begin : g_bad_n
      $error("segdac_switch_reg: at least two switches required");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (!hold) q <= d;
   end

   // reset always lands on the all-off A pattern
   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (q == '0)); // R9
endmodule

// File: rtl/segdac_switch_front.sv
module segdac_switch_front
   import segdac_pkg::*;
#(
   parameter int unsigned CODE_W = CODE_W_DEF,
   parameter int unsigned BIN_W  = BIN_W_DEF,
   localparam int unsigned HI_W  = CODE_W - BIN_W,
   localparam int unsigned SEG_N = therm_cells(HI_W),
   localparam int unsigned SW_N  = SEG_N + BIN_W,
   localparam int unsigned SEG_WT = cell_weight(BIN_W),
   localparam int unsigned FULL  = (1 << CODE_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [SEG_N-1:0]  seg_a_o,
   output logic [SEG_N-1:0]  seg_b_o,
   output logic [BIN_W-1:0]  bin_a_o,
   output logic [BIN_W-1:0]  bin_b_o
);
   if (SEG_N * SEG_WT + SEG_WT - 1 != FULL) begin : g_bad_geom
      $error("segdac_switch_front: cell weights do not span full scale");
   end

   logic [CODE_W-1:0] code_q;
   logic [SEG_N-1:0]  therm_d;
   logic [BIN_W-1:0]  bin_d;
   logic [SW_N-1:0]   sw_q;
   logic [SW_N-1:0]   leg_a;
   logic [SW_N-1:0]   leg_b;

   // stage one: input capture
   segdac_code_reg #(.W(CODE_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .hold(sleep_i), .d(code_i), .q(code_q));

   // split into thermometer cells and binary cells
   segdac_decoder #(.CODE_W(CODE_W), .BIN_W(BIN_W)) u_dec (
      .code(code_q), .therm(therm_d), .bin(bin_d));

   // stage two: switch enables, segments above the binary cells
   segdac_switch_reg #(.N(SW_N)) u_sw (
      .clk(clk), .rst_n(rst_n), .hold(sleep_i),
      .d({therm_d, bin_d}), .q(sw_q));

   // one complementary leg pair per switch, both legs off in sleep
   for (genvar i = 0; i < SW_N; i++) begin : g_leg
      assign leg_a[i] = ~sleep_i &  sw_q[i];
      assign leg_b[i] = ~sleep_i & ~sw_q[i];
   end

   assign seg_a_o = leg_a[SW_N-1:BIN_W];
   assign seg_b_o = leg_b[SW_N-1:BIN_W];
   assign bin_a_o = leg_a[BIN_W-1:0];
   assign bin_b_o = leg_b[BIN_W-1:0];

   // weighted current of one side, in LSB units
   function automatic int unsigned side_sum(input logic [SEG_N-1:0] s,
                                            input logic [BIN_W-1:0] b);
      int unsigned acc = 0;
      for (int k = 0; k < SEG_N; k++) if (s[k]) acc += SEG_WT;
      for (int k = 0; k < BIN_W; k++) if (b[k]) acc += (1 << k);
      return acc;
   endfunction

   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> (seg_a_o == '0 && seg_b_o == '0 &&
                   bin_a_o == '0 && bin_b_o == '0)); // R7

   AST_LEGS_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_i |-> (seg_b_o == ~seg_a_o && bin_b_o == ~bin_a_o)); // R4

   AST_FULL_SCALE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_i |-> (side_sum(seg_a_o, bin_a_o) + side_sum(seg_b_o, bin_b_o) == FULL)); // R5

   AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && $past(!sleep_i) && $past(rst_n) && $past(rst_n, 2) && $past(!sleep_i, 2))
      |-> (side_sum(seg_a_o, bin_a_o) == 32'($past(code_i, 2)))); // R1
endmodule

// File: tb/sim_segdac_switch_front.sv
module sim_segdac_switch_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_i = 1'b0;
   logic [7:0]  code_i = 8'h00;
   logic [30:0] seg_a_o, seg_b_o;
   logic [2:0]  bin_a_o, bin_b_o;

   int n_chk = 0;
   int n_bad = 0;
   bit mon_en = 1'b0;
   bit done = 1'b0;
   int unsigned expq[$];

   always #5 clk = ~clk;

   segdac_switch_front u0 (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .code_i(code_i),
      .seg_a_o(seg_a_o), .seg_b_o(seg_b_o), .bin_a_o(bin_a_o), .bin_b_o(bin_b_o));

   task automatic check(input string tag, input bit ok, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [30:0] therm_of(input int unsigned c);
      logic [30:0] t;
      for (int k = 0; k < 31; k++) t[k] = ((c >> 3) > k);
      return t;
   endfunction

   function automatic int unsigned wsum(input logic [30:0] s, input logic [2:0] b);
      return 8 * $countones(s) + b;
   endfunction

   // compare the outputs against one expected code
   task automatic check_code(input string where, input int unsigned c);
      logic [30:0] es;
      es = therm_of(c);
      check({where, " R1 R2 segments"}, seg_a_o == es, seg_a_o, es);
      check({where, " R3 binary"}, bin_a_o == c[2:0], bin_a_o, c[2:0]);
      check({where, " R4 complement"}, (seg_b_o == ~seg_a_o) && (bin_b_o == ~bin_a_o),
            {seg_b_o, bin_b_o}, {~seg_a_o, ~bin_a_o});
      check({where, " R5 A sum"}, wsum(seg_a_o, bin_a_o) == c, wsum(seg_a_o, bin_a_o), c);
      check({where, " R5 total"}, wsum(seg_a_o, bin_a_o) + wsum(seg_b_o, bin_b_o) == 255,
            wsum(seg_a_o, bin_a_o) + wsum(seg_b_o, bin_b_o), 255);
   endtask

   // driver: applies one code per cycle and records what must come out
   task automatic drive(input int unsigned c);
      @(negedge clk);
      code_i = c[7:0];
      if (mon_en) expq.push_back(c);
   endtask

   // monitor: two edges after a code was applied, it must be on the legs
   int unsigned prev_c = 0;
   logic [30:0] prev_seg = '0;
   bit have_prev = 1'b0;
   always @(posedge clk) begin
      #2;
      if (mon_en && expq.size() >= 2) begin
         int unsigned c;
         c = expq.pop_front();
         check_code("stream", c);
         if (have_prev && prev_c[2:0] == 3'b111 && c == prev_c + 1) begin
            check("R6 low cells off", bin_a_o == 3'b000, bin_a_o, 0);
            check("R6 one more segment", $countones(seg_a_o) == $countones(prev_seg) + 1,
                  $countones(seg_a_o), $countones(prev_seg) + 1);
         end
         prev_c = c;
         prev_seg = seg_a_o;
         have_prev = 1'b1;
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   task automatic stop_stream;
      mon_en = 1'b0;
      repeat (3) @(negedge clk);
      expq.delete();
      have_prev = 1'b0;
   endtask

   initial begin
      int unsigned lcg;
      // reset state
      repeat (3) @(negedge clk);
      #1;
      check("R9 reset A legs", {seg_a_o, bin_a_o} == '0, {seg_a_o, bin_a_o}, 0);
      check("R9 reset B legs", {seg_b_o, bin_b_o} == '1, {seg_b_o, bin_b_o}, 34'h3_FFFF_FFFF);
      @(negedge clk);
      rst_n = 1'b1;

      // full ramp covers every carry (R6) and both ends
      mon_en = 1'b1;
      for (int c = 0; c < 256; c++) drive(c);
      // extremes and midscale neighbours
      drive(8'h80); drive(8'h7F); drive(8'h80); drive(8'hFF); drive(8'h00);
      drive(8'hFF); drive(8'h07); drive(8'h08); drive(8'hF8); drive(8'hF7);
      // pseudo-random codes
      lcg = 32'h1234_5678;
      for (int i = 0; i < 60; i++) begin
         lcg = lcg * 1103515245 + 12345;
         drive((lcg >> 16) & 8'hFF);
      end
      drive(8'h00); drive(8'h00); drive(8'h00);
      stop_stream();

      // sleep window: R7 quiet legs, R8 frozen pipeline
      @(negedge clk); code_i = 8'h5A;
      @(negedge clk); code_i = 8'hC3;
      @(negedge clk); sleep_i = 1'b1; code_i = 8'h11;
      #1;
      check("R7 sleep A legs", {seg_a_o, bin_a_o} == '0, {seg_a_o, bin_a_o}, 0);
      check("R7 sleep B legs", {seg_b_o, bin_b_o} == '0, {seg_b_o, bin_b_o}, 0);
      repeat (2) @(negedge clk);
      code_i = 8'h22;
      @(negedge clk);
      #1;
      check("R7 sleep still quiet", {seg_a_o, bin_a_o, seg_b_o, bin_b_o} == '0,
            {seg_a_o, bin_a_o, seg_b_o, bin_b_o}, 0);
      sleep_i = 1'b0; code_i = 8'h33;
      #1;
      check_code("R8 held stage two", 8'h5A);
      @(posedge clk); #2;
      check_code("R8 held stage one", 8'hC3);
      @(posedge clk); #2;
      check_code("R8 fresh code", 8'h33);

      // reset in mid-stream
      @(negedge clk); code_i = 8'hFF;
      repeat (2) @(negedge clk);
      #1;
      check_code("R1 before reset", 8'hFF);
      rst_n = 1'b0;
      @(posedge clk); #2;
      check("R9 mid reset A legs", {seg_a_o, bin_a_o} == '0, {seg_a_o, bin_a_o}, 0);
      check("R9 mid reset B legs", {seg_b_o, bin_b_o} == '1, {seg_b_o, bin_b_o}, 34'h3_FFFF_FFFF);
      @(negedge clk); rst_n = 1'b1; code_i = 8'h00;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule